// File: doc/BRIEF.md
# Video Timing Mode Detector

The detector watches a pair of normalized, active-high sync signals with a free-running sample clock. It measures four quantities: clocks between successive line-sync leading edges, line-sync width in clocks, lines per frame, and frame-sync width in lines. At every frame start it compares the line period and the frame length with a built-in table of display modes. From the match it reports a mode index, a lock flag and a recommended PLL feedback divider. It also produces a data-enable strobe that marks which continuously taken samples fall in the active picture.

A line runs from the leading edge of its sync: the sync pulse, then the back porch, then the active pixels, then the front porch. A frame starts on the first line whose sync edge sees frame sync asserted after a line that did not. The table is a parameter. Its default holds four modes. Line totals are 1056, 1344, 1688 and 2160 clocks. Frame totals are 628, 806, 1066 and 1250 lines. The pixel clocks of these modes are 40, 65, 108 and 162 MHz.

Top module: `vidmode_detect`

## Requirements
- R1: `line_clks` holds the number of clocks from one line-sync leading edge to the next, and `hsync_clks` holds how many consecutive samples the last line-sync pulse was high.
- R2: At each frame start, `frame_lines` takes the number of line starts in the frame that just ended, and `vsync_lines` takes how many of those lines began with frame sync high.
- R3: At a frame start, table entry i matches when the measured line period is within ±TOL (default 2) of the entry's horizontal sum and the measured line count equals its vertical sum exactly. `mode_idx` then shows i, and the lowest matching index wins.
- R4: When no entry matches, `mode_idx` shows the reserved code NUM_MODES (4), `mode_valid` is low, and the raw measurements are still reported.
- R5: While the current classification is a match, `pll_div` equals the matched entry's front porch + sync + back porch + active; otherwise it equals `line_clks`.
- R6: `mode_valid` rises at the frame start where the same entry has matched for the second consecutive frame start.
- R7: While valid, a line start whose measured period lies outside ±TOL of the locked entry clears `mode_valid` at once. Two further matching frame starts are needed to regain it.
- R8: `pix_de` is high for horizontal sample positions p (p = 0 at the first sample with line sync high) where sync+back ≤ p < sync+back+active, taken from the locked entry. The strobe for the sample taken at clock edge n is shown after edge n+1.
- R9: `pix_de` is also limited to lines q of the frame (q = 0 for the frame-start line) where vsync+vback ≤ q < vsync+vback+vactive.
- R10: `pix_de` stays low whenever `mode_valid` is low.
- R11: After reset, `mode_idx` is 4, `mode_valid`, `pix_de`, `line_clks` and `pll_div` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_in | input | 1 | Normalized line sync, active high |
| vsync_in | input | 1 | Normalized frame sync, active high |
| mode_idx | output | IDX_W (3) | Matched table entry, or 4 for unknown |
| mode_valid | output | 1 | Locked on a mode |
| line_clks | output | HCW | Measured clocks per line |
| hsync_clks | output | HCW | Measured line-sync width |
| frame_lines | output | LCW | Measured lines per frame |
| vsync_lines | output | LCW | Measured frame-sync width in lines |
| pll_div | output | HCW | Recommended PLL feedback divider |
| pix_de | output | 1 | Active-sample strobe |

## Verification
An input sample is registered at edge n, and edge detection and the counters update at edge n+1. Every result therefore shows two clock edges after the sync change that causes it. The bench drives inputs on falling edges and judges `pix_de` and `mode_valid` for each sample two falling edges after it drove that sample, using a two-deep record of expectations. Lock-dependent samples are checked only from the third frame of each pattern on. Measurements, index and divider are read after the last sample of a pattern, when all updates have settled.

// File: rtl/vidmode_pkg.sv
`timescale 1ns/1ps
package vidmode_pkg;
   localparam int NUM_MODES = 4;
   localparam int FW        = 16;
   localparam int IDX_W     = $clog2(NUM_MODES + 1);
   localparam logic [IDX_W-1:0] IDX_NONE = IDX_W'(NUM_MODES);

   typedef struct packed {
      logic [FW-1:0] h_sync;
      logic [FW-1:0] h_back;
      logic [FW-1:0] h_act;
      logic [FW-1:0] h_front;
      logic [FW-1:0] v_sync;
      logic [FW-1:0] v_back;
      logic [FW-1:0] v_act;
      logic [FW-1:0] v_front;
   } vmode_t;

   typedef vmode_t [NUM_MODES-1:0] vmode_tab_t;

   function automatic vmode_t mk_mode(input int hf, input int hs, input int hb, input int ha,
                                      input int vf, input int vs, input int vb, input int va);
      vmode_t m;
      m.h_front = FW'(hf);
      m.h_sync  = FW'(hs);
      m.h_back  = FW'(hb);
      m.h_act   = FW'(ha);
      m.v_front = FW'(vf);
      m.v_sync  = FW'(vs);
      m.v_back  = FW'(vb);
      m.v_act   = FW'(va);
      return m;
   endfunction

   function automatic int h_total(input vmode_t m);
      return int'(m.h_front) + int'(m.h_sync) + int'(m.h_back) + int'(m.h_act);
   endfunction

   function automatic int v_total(input vmode_t m);
      return int'(m.v_front) + int'(m.v_sync) + int'(m.v_back) + int'(m.v_act);
   endfunction

   localparam vmode_tab_t DEFAULT_TAB = {
      mk_mode(64, 192, 304, 1600, 1, 3, 46, 1200),
      mk_mode(48, 112, 248, 1280, 1, 3, 38, 1024),
      mk_mode(24, 136, 160, 1024, 3, 6, 29, 768),
      mk_mode(40, 128,  88,  800, 1, 4, 23, 600)
   };
endpackage

// File: rtl/vidmode_hmeas.sv
`timescale 1ns/1ps
module vidmode_hmeas #(
   parameter int HCW = 12
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           hs_s,
   output logic           line_start,
   output logic [HCW-1:0] hpos,
   output logic [HCW-1:0] period_now,
   output logic [HCW-1:0] period,
   output logic [HCW-1:0] sync_w
);
   localparam logic [HCW-1:0] CMAX = '1;

   logic           hs_d;
   logic           fall;
   logic [HCW-1:0] wcnt;

   assign line_start = hs_s & ~hs_d;
   assign fall       = ~hs_s & hs_d;
   assign period_now = (hpos == CMAX) ? CMAX : hpos + HCW'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hs_d   <= 1'b0;
         hpos   <= '0;
         period <= '0;
         wcnt   <= '0;
         sync_w <= '0;
      end else begin
         hs_d <= hs_s;
         if (line_start) begin
            hpos   <= '0;
            period <= period_now;
         end else if (hpos != CMAX) begin
            hpos <= hpos + HCW'(1);
         end
         if (line_start)
            wcnt <= HCW'(1);
         else if (hs_s && wcnt != CMAX)
            wcnt <= wcnt + HCW'(1);
         if (fall)
            sync_w <= wcnt;
      end
   end

   assert_sync_nonzero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> (sync_w != '0));
endmodule

// File: rtl/vidmode_vmeas.sv
`timescale 1ns/1ps
module vidmode_vmeas #(
   parameter int LCW = 11
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           line_start,
   input  logic           vs_s,
   output logic           frame_start,
   output logic [LCW-1:0] lines_now,
   output logic [LCW-1:0] vpos,
   output logic [LCW-1:0] frame_lines,
   output logic [LCW-1:0] vsync_lines
);
   localparam logic [LCW-1:0] LMAX = '1;

   logic           vs_line;
   logic [LCW-1:0] lcnt;
   logic [LCW-1:0] vcnt;

   assign frame_start = line_start & vs_s & ~vs_line;
   assign lines_now   = lcnt;
   assign vpos        = lcnt - LCW'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vs_line     <= 1'b0;
         lcnt        <= '0;
         vcnt        <= '0;
         frame_lines <= '0;
         vsync_lines <= '0;
      end else if (line_start) begin
         vs_line <= vs_s;
         if (frame_start) begin
            frame_lines <= lcnt;
            vsync_lines <= vcnt;
            lcnt        <= LCW'(1);
            vcnt        <= LCW'(1);
         end else begin
            if (lcnt != LMAX)
               lcnt <= lcnt + LCW'(1);
            if (vs_s && vcnt != LMAX)
               vcnt <= vcnt + LCW'(1);
         end
      end
   end

   assert_vsync_within_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (vsync_lines <= frame_lines));
endmodule

// File: rtl/vidmode_classify.sv
`timescale 1ns/1ps
module vidmode_classify import vidmode_pkg::*; #(
   parameter int         HCW = 12,
   parameter int         LCW = 11,
   parameter int         TOL = 2,
   parameter vmode_tab_t TAB = DEFAULT_TAB
) (
   input  logic [HCW-1:0]   period,
   input  logic [LCW-1:0]   lines,
   output logic             hit,
   output logic [IDX_W-1:0] idx
);
   logic [NUM_MODES-1:0] match;

   for (genvar i = 0; i < NUM_MODES; i++) begin : g_cmp
      localparam int HT = h_total(TAB[i]);
      localparam int VT = v_total(TAB[i]);
      if (HT + TOL >= (1 << HCW)) begin : g_hbad
         $error("mode %0d line total does not fit the clock counter", i);
      end
      if (VT >= (1 << LCW)) begin : g_vbad
         $error("mode %0d frame total does not fit the line counter", i);
      end
      if (TOL == 0) begin : g_exact
         assign match[i] = (int'(period) == HT) && (int'(lines) == VT);
      end else begin : g_window
         assign match[i] = (int'(period) + TOL >= HT) && (int'(period) <= HT + TOL)
                           && (int'(lines) == VT);
      end
   end

   always_comb begin
      hit = |match;
      idx = IDX_NONE;
      for (int i = NUM_MODES - 1; i >= 0; i--)
         if (match[i]) idx = IDX_W'(i);
   end
endmodule

// File: rtl/vidmode_detect.sv
`timescale 1ns/1ps
module vidmode_detect import vidmode_pkg::*; #(
   parameter int         HCW      = 12,
   parameter int         LCW      = 11,
   parameter int         TOL      = 2,
   parameter vmode_tab_t MODE_TAB = DEFAULT_TAB
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hsync_in,
   input  logic             vsync_in,
   output logic [IDX_W-1:0] mode_idx,
   output logic             mode_valid,
   output logic [HCW-1:0]   line_clks,
   output logic [HCW-1:0]   hsync_clks,
   output logic [LCW-1:0]   frame_lines,
   output logic [LCW-1:0]   vsync_lines,
   output logic [HCW-1:0]   pll_div,
   output logic             pix_de
);
   if (HCW < 4 || LCW < 2) begin : g_wbad
      $error("counter widths too small");
   end
   if (TOL < 0) begin : g_tbad
      $error("tolerance must not be negative");
   end

   logic             hs_s, vs_s;
   logic             line_start, frame_start;
   logic [HCW-1:0]   hpos, period_now;
   logic [LCW-1:0]   lines_now, vpos;
   logic             cls_hit;
   logic [IDX_W-1:0] cls_idx;
   logic [IDX_W-1:0] cur_idx;
   logic             cur_hit, valid;
   vmode_t           sel;
   int               sel_ht, h_lo, v_lo;
   logic             line_ok, h_in, v_in;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hs_s <= 1'b0;
         vs_s <= 1'b0;
      end else begin
         hs_s <= hsync_in;
         vs_s <= vsync_in;
      end
   end

   vidmode_hmeas #(.HCW(HCW)) u_hmeas (
      .clk(clk), .rst_n(rst_n), .hs_s(hs_s), .line_start(line_start),
      .hpos(hpos), .period_now(period_now), .period(line_clks), .sync_w(hsync_clks));

   vidmode_vmeas #(.LCW(LCW)) u_vmeas (
      .clk(clk), .rst_n(rst_n), .line_start(line_start), .vs_s(vs_s),
      .frame_start(frame_start), .lines_now(lines_now), .vpos(vpos),
      .frame_lines(frame_lines), .vsync_lines(vsync_lines));

   vidmode_classify #(.HCW(HCW), .LCW(LCW), .TOL(TOL), .TAB(MODE_TAB)) u_classify (
      .period(period_now), .lines(lines_now), .hit(cls_hit), .idx(cls_idx));

   always_comb begin
      sel = '0;
      for (int i = 0; i < NUM_MODES; i++)
         if (cur_idx == IDX_W'(i)) sel = MODE_TAB[i];
      sel_ht  = h_total(sel);
      line_ok = (int'(period_now) + TOL >= sel_ht) && (int'(period_now) <= sel_ht + TOL);
      h_lo    = int'(sel.h_sync) + int'(sel.h_back);
      v_lo    = int'(sel.v_sync) + int'(sel.v_back);
      h_in    = (int'(hpos) >= h_lo) && (int'(hpos) < h_lo + int'(sel.h_act));
      v_in    = (int'(vpos) >= v_lo) && (int'(vpos) < v_lo + int'(sel.v_act));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_idx <= IDX_NONE;
         cur_hit <= 1'b0;
         valid   <= 1'b0;
      end else if (frame_start) begin
         cur_idx <= cls_hit ? cls_idx : IDX_NONE;
         cur_hit <= cls_hit;
         valid   <= cls_hit && cur_hit && (cls_idx == cur_idx);
      end else if (line_start && !line_ok) begin
         cur_hit <= 1'b0;
         valid   <= 1'b0;
      end
   end

   assign mode_idx   = cur_idx;
   assign mode_valid = valid;
   assign pll_div    = cur_hit ? HCW'(sel_ht) : line_clks;
   assign pix_de     = valid && h_in && v_in;

   assert_de_needs_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pix_de |-> mode_valid);
   assert_lock_at_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mode_valid) |-> $past(frame_start));
   assert_idx_in_table_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mode_valid |-> (mode_idx < IDX_W'(NUM_MODES)));
   assert_lines_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mode_valid |-> (int'(frame_lines) == v_total(sel)));
   assert_drop_bad_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start && !line_ok) |=> !mode_valid);
   assert_div_near_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mode_valid |-> ((int'(line_clks) + TOL >= int'(pll_div))
                      && (int'(line_clks) <= int'(pll_div) + TOL)));
endmodule

// File: tb/vidmode_detect_bench.sv
`timescale 1ns/1ps
module vidmode_detect_bench;
   import vidmode_pkg::*;

   localparam int HCW = 12;
   localparam int LCW = 11;
   localparam vmode_tab_t TB_TAB = {
      mk_mode(3, 5, 4, 14, 2, 2, 2, 8),
      mk_mode(3, 3, 4, 12, 1, 3, 2, 6),
      mk_mode(2, 4, 3, 10, 1, 2, 2, 5),
      mk_mode(2, 3, 2,  8, 1, 2, 1, 4)
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             hsync_in = 1'b0;
   logic             vsync_in = 1'b0;
   logic [IDX_W-1:0] mode_idx;
   logic             mode_valid;
   logic [HCW-1:0]   line_clks, hsync_clks, pll_div;
   logic [LCW-1:0]   frame_lines, vsync_lines;
   logic             pix_de;

   int total = 0;
   int bad   = 0;

   // expectation record, two samples deep
   bit    h0_chk = 0, h0_v = 0, h0_de = 0;
   bit    h1_chk = 0, h1_v = 0, h1_de = 0;
   string h0_rv = "R6", h0_rd = "R8", h1_rv = "R6", h1_rd = "R8";

   always #2.5 clk = ~clk;

   vidmode_detect #(.HCW(HCW), .LCW(LCW), .TOL(2), .MODE_TAB(TB_TAB)) u_vidmode_detect (
      .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
      .mode_idx(mode_idx), .mode_valid(mode_valid), .line_clks(line_clks),
      .hsync_clks(hsync_clks), .frame_lines(frame_lines), .vsync_lines(vsync_lines),
      .pll_div(pll_div), .pix_de(pix_de));

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic finish_up();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   task automatic check_hist();
      if (h1_chk) begin
         chk(h1_rv, "mode_valid per sample", int'(mode_valid), int'(h1_v));
         chk(h1_rd, "pix_de per sample", int'(pix_de), int'(h1_de));
      end
   endtask

   // one scenario: nfr frames of one timing, optional stretched line (gf, gl)
   task automatic run_mode(input string name, input int hf, input int hs, input int hb,
                           input int ha, input int vf, input int vs, input int vb,
                           input int va, input int nfr, input int exp_idx,
                           input int exp_pll, input int gf, input int gl);
      int htot, vtot;
      bit known;
      htot  = hf + hs + hb + ha;
      vtot  = vf + vs + vb + va;
      known = (exp_idx < NUM_MODES);
      $display("scenario %s", name);
      for (int f = 0; f < nfr; f++) begin
         for (int l = 0; l < vtot; l++) begin
            int  len;
            bit  glitched, in_v;
            len      = htot + ((f == gf && l == gl) ? 5 : 0);
            glitched = (gf >= 0) && ((f == gf && l > gl) || f == gf + 1);
            in_v     = (l >= vs + vb) && (l < vs + vb + va);
            for (int j = 0; j < len; j++) begin
               bit ev, in_h;
               @(negedge clk);
               check_hist();
               ev   = known && !glitched;
               in_h = (j >= hs + hb) && (j < hs + hb + ha);
               h1_chk = h0_chk; h1_v = h0_v; h1_de = h0_de; h1_rv = h0_rv; h1_rd = h0_rd;
               h0_chk = (f >= 2);
               h0_v   = ev;
               h0_de  = ev && in_h && in_v;
               h0_rv  = glitched ? "R7" : (known ? "R6" : "R4");
               h0_rd  = !ev ? "R10" : (!in_v ? "R9" : "R8");
               hsync_in = (j < hs);
               vsync_in = (l < vs);
            end
         end
      end
      chk(known ? "R3" : "R4", "mode_idx", int'(mode_idx), exp_idx);
      chk(known ? "R6" : "R4", "mode_valid", int'(mode_valid), int'(known));
      chk("R1", "line_clks", int'(line_clks), htot);
      chk("R1", "hsync_clks", int'(hsync_clks), hs);
      chk("R2", "frame_lines", int'(frame_lines), vtot);
      chk("R2", "vsync_lines", int'(vsync_lines), vs);
      chk(known ? "R5" : "R4", "pll_div", int'(pll_div), exp_pll);
   endtask

   task automatic test_reset();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R11", "reset mode_idx", int'(mode_idx), NUM_MODES);
      chk("R11", "reset mode_valid", int'(mode_valid), 0);
      chk("R11", "reset pix_de", int'(pix_de), 0);
      chk("R11", "reset line_clks", int'(line_clks), 0);
      chk("R11", "reset pll_div", int'(pll_div), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_up();
   end

   initial begin
      test_reset();
      // R3 R6 R8 R9: exact modes
      run_mode("mode0", 2, 3, 2, 8, 1, 2, 1, 4, 4, 0, 15, -1, -1);
      run_mode("mode3", 3, 5, 4, 14, 2, 2, 2, 8, 4, 3, 26, -1, -1);
      run_mode("mode1", 2, 4, 3, 10, 1, 2, 2, 5, 4, 1, 19, -1, -1);
      // R3 R5: tolerance edges, divider from the table
      run_mode("mode1 plus2", 4, 4, 3, 10, 1, 2, 2, 5, 4, 1, 19, -1, -1);
      run_mode("mode1 minus2", 0, 4, 3, 10, 1, 2, 2, 5, 4, 1, 19, -1, -1);
      // R4: beyond tolerance, and line count off by one
      run_mode("plus3 unknown", 5, 4, 3, 10, 1, 2, 2, 5, 4, NUM_MODES, 22, -1, -1);
      run_mode("lines unknown", 2, 3, 2, 8, 1, 2, 1, 5, 4, NUM_MODES, 15, -1, -1);
      // R7: one stretched line while locked
      run_mode("mode2 glitch", 3, 3, 4, 12, 1, 3, 2, 6, 6, 2, 22, 3, 2);
      finish_up();
   end
endmodule